// File: doc/BRIEF.md
# Rounding Averaging Add/Subtract Unit

This block takes two ELEM_W-bit elements and returns their average or their half-difference. It has four operations: unsigned add, signed add, unsigned subtract and signed subtract. Each operand gains one extra bit, by zero extension for the unsigned forms and by sign extension for the signed forms. The block then forms the exact sum or difference, shifts it right by one bit and adds a rounding increment. A 2-bit mode input chooses how the increment is taken from the bit that the shift discards.

A vector datapath uses one copy of the block per element lane. An active flag comes with each element. When it is low, the block passes the old destination element through unchanged. The arithmetic is combinational and feeds a single output register, so the latency is one cycle. ELEM_W may be 8, 16, 32 or 64.

Top module: `halving_avg_unit`

## Requirements
- R1: While `rst` is high at a clock edge, `out_valid` and `out_data` become 0.
- R2: `out_valid` equals the value `in_valid` had at the previous clock edge, so the latency is one cycle.
- R3: Unsigned add (`op`=0) computes the (ELEM_W+1)-bit zero-extended sum `src_b`+`src_a`. The base result is bits ELEM_W:1 of that sum.
- R4: Signed add (`op`=1) uses sign-extended operands. Its base result is bits ELEM_W:1 of the (ELEM_W+1)-bit sum.
- R5: Unsigned subtract (`op`=2) computes `src_b` minus `src_a` on zero-extended operands, in that order. The base result is bits ELEM_W:1 of the difference.
- R6: Signed subtract (`op`=3) computes `src_b` minus `src_a` on sign-extended operands. The base result is bits ELEM_W:1 of the difference.
- R7: Mode 0 (nearest, ties up) adds bit 0 of the widened value to the base result. The addition wraps modulo 2^ELEM_W.
- R8: Mode 1 (nearest, ties to even) adds bit0 AND bit1 of the widened value.
- R9: Mode 2 (truncate) adds nothing.
- R10: Mode 3 (jam to odd) adds bit0 AND NOT bit1 of the widened value.
- R11: When `in_valid` is high and `active` is low, `out_data` takes `old_dst` on the next cycle.
- R12: When `in_valid` is low, `out_data` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Element present this cycle |
| op | input | 2 | 0 unsigned add, 1 signed add, 2 unsigned sub, 3 signed sub |
| rmode | input | 2 | 0 nearest-up, 1 nearest-even, 2 truncate, 3 jam-to-odd |
| active | input | 1 | Element enabled; low selects `old_dst` |
| src_a | input | ELEM_W | First operand (the subtrahend for the subtract operations) |
| src_b | input | ELEM_W | Second operand (the minuend for the subtract operations) |
| old_dst | input | ELEM_W | Previous destination element |
| out_valid | output | 1 | Result present |
| out_data | output | ELEM_W | Registered result |

## Verification
The checks assume that `in_valid` is low during reset, so that no element straddles reset release. The bench drives inputs only after the falling edge and holds `in_valid` low while `rst` is high. The unsigned-add bound check relies on the inputs being sampled in the cycle before the result appears. The bench meets this by keeping each element for exactly one valid cycle and then returning `in_valid` to low. Operands cover the extreme values, including signed minimum plus signed minimum and zero minus all-ones, which the widened arithmetic must handle without overflow.

// File: rtl/avg_pkg.sv
package avg_pkg;
  typedef enum logic [1:0] {
    OP_ADDU = 2'd0,
    OP_ADDS = 2'd1,
    OP_SUBU = 2'd2,
    OP_SUBS = 2'd3
  } avg_op_e;

  typedef enum logic [1:0] {
    RM_NUP   = 2'd0,
    RM_NEVEN = 2'd1,
    RM_DOWN  = 2'd2,
    RM_ODD   = 2'd3
  } avg_rmode_e;
endpackage

// File: rtl/avg_widen.sv
module avg_widen #(
  parameter int W = 8
) (
  input  avg_pkg::avg_op_e op,
  input  logic [W-1:0]     a,
  input  logic [W-1:0]     b,
  output logic [W:0]       wide
);
  logic ext_a_msb, ext_b_msb;
  logic [W:0] xa, xb;
  logic is_signed, is_sub;

  always_comb begin
    is_signed = op[0];
    is_sub    = op[1];
    ext_a_msb = is_signed & a[W-1];
    ext_b_msb = is_signed & b[W-1];
    xa = {ext_a_msb, a};
    xb = {ext_b_msb, b};
    wide = is_sub ? (xb - xa) : (xb + xa);
  end
endmodule

// File: rtl/avg_round.sv
module avg_round (
  input  avg_pkg::avg_rmode_e rmode,
  input  logic                d1,
  input  logic                d0,
  output logic                incr
);
  always_comb begin
    unique case (rmode)
      avg_pkg::RM_NUP:   incr = d0;
      avg_pkg::RM_NEVEN: incr = d0 & d1;
      avg_pkg::RM_DOWN:  incr = 1'b0;
      avg_pkg::RM_ODD:   incr = d0 & ~d1;
      default:           incr = 1'b0;
    endcase
  end

  // R9
  always_comb begin
    rdn_no_incr_chk: assert (!(rmode == avg_pkg::RM_DOWN && incr));
  end
endmodule

// File: rtl/avg_halve.sv
module avg_halve #(
  parameter int W = 8
) (
  input  logic [W:0]   wide,
  input  logic         incr,
  output logic [W-1:0] res
);
  localparam int PADW = W - 1;
  logic [W-1:0] base;

  always_comb begin
    base = wide[W:1];
    res  = base + {{PADW{1'b0}}, incr};
  end
endmodule

// File: rtl/halving_avg_unit.sv
module halving_avg_unit #(
  parameter int ELEM_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [1:0]        op,
  input  logic [1:0]        rmode,
  input  logic              active,
  input  logic [ELEM_W-1:0] src_a,
  input  logic [ELEM_W-1:0] src_b,
  input  logic [ELEM_W-1:0] old_dst,
  output logic              out_valid,
  output logic [ELEM_W-1:0] out_data
);
  import avg_pkg::*;

  avg_op_e           op_e;
  avg_rmode_e        rm_e;
  logic [ELEM_W:0]   wide;
  logic              incr;
  logic [ELEM_W-1:0] avg_res;
  logic [ELEM_W-1:0] next_data;

  always_comb begin
    op_e = avg_op_e'(op);
    rm_e = avg_rmode_e'(rmode);
  end

  avg_widen #(.W(ELEM_W)) u_widen (
    .op   (op_e),
    .a    (src_a),
    .b    (src_b),
    .wide (wide)
  );

  avg_round u_round (
    .rmode (rm_e),
    .d1    (wide[1]),
    .d0    (wide[0]),
    .incr  (incr)
  );

  avg_halve #(.W(ELEM_W)) u_halve (
    .wide (wide),
    .incr (incr),
    .res  (avg_res)
  );

  always_comb next_data = active ? avg_res : old_dst;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_data <= next_data;
    end
  end

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  // R2
  valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  // R12
  hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_data));
  // R11
  masked_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !active) |=> (out_data == $past(old_dst)));
  // R3
  uadd_bounds_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && active && op == 2'd0) |=>
      ((out_data >= $past(src_a) || out_data >= $past(src_b)) &&
       (out_data <= $past(src_a) || out_data <= $past(src_b))));
endmodule

// File: tb/test_halving_avg_unit.sv
module test_halving_avg_unit;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst;
  logic in_valid;
  logic [1:0] op, rmode;
  logic active;
  logic [W-1:0] src_a, src_b, old_dst;
  logic out_valid;
  logic [W-1:0] out_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  halving_avg_unit #(.ELEM_W(W)) i_halving_avg_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .rmode(rmode),
    .active(active), .src_a(src_a), .src_b(src_b), .old_dst(old_dst),
    .out_valid(out_valid), .out_data(out_data)
  );

  // {op, rmode, a, b, expected}
  localparam int NV = 12;
  localparam logic [27:0] VEC [NV] = '{
    {2'd0, 2'd0, 8'hFF, 8'hFF, 8'hFF},
    {2'd1, 2'd0, 8'h7F, 8'h7F, 8'h7F},
    {2'd1, 2'd2, 8'h80, 8'h80, 8'h80},
    {2'd2, 2'd0, 8'hFF, 8'h00, 8'h81},
    {2'd3, 2'd2, 8'h7F, 8'h80, 8'h80},
    {2'd3, 2'd1, 8'h7F, 8'h80, 8'h80},
    {2'd3, 2'd3, 8'h7F, 8'h80, 8'h81},
    {2'd0, 2'd1, 8'h01, 8'h02, 8'h02},
    {2'd0, 2'd3, 8'h01, 8'h02, 8'h01},
    {2'd0, 2'd0, 8'h01, 8'h02, 8'h02},
    {2'd2, 2'd2, 8'h03, 8'h00, 8'hFE},
    {2'd0, 2'd1, 8'h00, 8'h01, 8'h00}
  };

  localparam logic [W-1:0] CORNER [6] = '{8'h00, 8'h01, 8'h7F, 8'h80, 8'hFE, 8'hFF};

  function automatic logic [W-1:0] ref_avg(input logic [1:0] o, input logic [1:0] m,
                                           input logic [W-1:0] a, input logic [W-1:0] b);
    longint ia, ib, s, base, inc;
    ia = o[0] ? longint'($signed(a)) : longint'(a);
    ib = o[0] ? longint'($signed(b)) : longint'(b);
    s = o[1] ? (ib - ia) : (ib + ia);
    base = s >>> 1;
    case (m)
      2'd0: inc = s & 1;
      2'd1: inc = (s & 1) & ((s >>> 1) & 1);
      2'd2: inc = 0;
      default: inc = (s & 1) & ~((s >>> 1) & 1) & 1;
    endcase
    return W'(base + inc);
  endfunction

  function automatic string tag(input logic [1:0] o, input logic [1:0] m);
    string t1, t2;
    case (o)
      2'd0: t1 = "R3"; 2'd1: t1 = "R4"; 2'd2: t1 = "R5"; default: t1 = "R6";
    endcase
    case (m)
      2'd0: t2 = "R7"; 2'd1: t2 = "R8"; 2'd2: t2 = "R9"; default: t2 = "R10";
    endcase
    return {t1, "/", t2};
  endfunction

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [1:0] o, input logic [1:0] m, input logic act,
                       input logic [W-1:0] a, input logic [W-1:0] b, input logic [W-1:0] od);
    @(negedge clk);
    in_valid = 1'b1; op = o; rmode = m; active = act;
    src_a = a; src_b = b; old_dst = od;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; in_valid = 1'b0; op = 2'd0; rmode = 2'd0; active = 1'b1;
    src_a = '0; src_b = '0; old_dst = '0;
    repeat (3) @(negedge clk);
    check("R1 valid", {7'd0, out_valid}, 8'h00);
    check("R1 data", out_data, 8'h00);
    rst = 1'b0;

    // Table of hand-computed vectors
    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][27:26], VEC[i][25:24], 1'b1, VEC[i][23:16], VEC[i][15:8], 8'h5A);
      check({"R2 ", tag(VEC[i][27:26], VEC[i][25:24])}, {7'd0, out_valid}, 8'h01);
      check(tag(VEC[i][27:26], VEC[i][25:24]), out_data, VEC[i][7:0]);
    end

    // Sweep of corner operands against the wide reference
    for (int o = 0; o < 4; o++)
      for (int m = 0; m < 4; m++)
        for (int x = 0; x < 6; x++)
          for (int y = 0; y < 6; y++) begin
            apply(2'(o), 2'(m), 1'b1, CORNER[x], CORNER[y], 8'h00);
            check(tag(2'(o), 2'(m)), out_data, ref_avg(2'(o), 2'(m), CORNER[x], CORNER[y]));
          end

    // R11: inactive element passes old destination
    apply(2'd0, 2'd0, 1'b0, 8'h10, 8'h20, 8'hC3);
    check("R11", out_data, 8'hC3);
    apply(2'd3, 2'd3, 1'b0, 8'h80, 8'h7F, 8'h3C);
    check("R11", out_data, 8'h3C);

    // R12: no valid, data holds while inputs change
    apply(2'd0, 2'd0, 1'b1, 8'h04, 8'h08, 8'h00);
    check("R3", out_data, 8'h06);
    @(negedge clk);
    op = 2'd1; src_a = 8'h77; src_b = 8'h11; active = 1'b0; old_dst = 8'hEE;
    @(negedge clk);
    check("R12 data", out_data, 8'h06);
    check("R2 idle", {7'd0, out_valid}, 8'h00);

    // R1: reset mid-stream clears outputs
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R1 data after run", out_data, 8'h00);
    rst = 1'b0;

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule